// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as a chain of packed-BCD counters. A clock divider makes a 128 Hz tick from the core clock. A 7-bit binary sub-second counter counts those ticks. When that counter wraps, the seconds advance, and the carry ripples through minutes, hours, day of week, day of month, month, year-in-century and century. The day of month wraps at the length of the current month, and that length follows the full Gregorian leap rule.

Software reaches the block through a byte-wide register port with a combinational read path. To set the clock, software stops the counters and clears the divider, writes every time and date field, and then sets enable and start together. Reading a full timestamp takes several byte reads, so a second may roll over in the middle of one. For that reason every second advance sets a sticky carry flag. Software clears the flag, reads the timestamp, and reads again if the flag is set once more. The flag can also drive an interrupt line. A one-cycle pulse marks each second boundary for neighbouring logic.

Top module: `cal_rtc`

## Requirements
- R1: After reset the registers read as follows.
  - Seconds, minutes, hours and day of week read 0x00.
  - Day of month reads 0x01 and month reads 0x01.
  - Year-in-century reads 0x00 and century reads 0x20.
  - The sub-second counter and both control registers read 0x00.
  - `sec_tick` and `carry_irq` are low.
- R2: The register map is as follows. Unused bits read 0.
  - Addresses 1 to 8 hold the time and date fields in packed BCD: seconds, minutes, hours, day of week, day of month, month, year-in-century, century.
  - Address 0 holds the sub-second count in bits 6:0.
  - Address 14 holds the carry flag in bit 7 and the carry-interrupt enable in bit 4.
  - Address 15 holds clock enable in bit 3, divider reset in bit 1 and start in bit 0.
  - Addresses 9 to 13 read 0x00 and ignore writes.
- R3: Counting runs only while enable=1, start=1 and divider reset=0.
  - The sub-second counter advances once every `PRESCALE_DIV` clocks.
  - After the divider is cleared and counting is started, `sec_tick` is first high in the cycle that follows 128·`PRESCALE_DIV`−1 rising edges after the start write.
  - `sec_tick` is high for exactly one cycle per second.
- R4: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day fields. Each field changes on the edge that ends the `sec_tick` cycle.
- R5: Day of week counts 0 to 6 and wraps from 6 to 0 at midnight.
- R6: Day of month wraps to 01 after the month's last day.
  - April, June, September and November end on day 30.
  - February ends on day 28, or on day 29 in a leap year.
  - All other months end on day 31.
  - Month wraps from 12 to 01 and carries into the year.
- R7: A year is a leap year when it is divisible by 4 and not by 100, or when it is divisible by 400. The year is century·100 + year-in-century.
- R8: Year-in-century wraps from 99 to 00 and increments the century. The century wraps from 99 to 00.
- R9: The carry flag is set on every seconds advance.
  - Writing 0 to bit 7 of address 14 clears the flag. Writing 1 leaves it unchanged.
  - If a set and a clear fall in the same cycle, the set wins.
- R10: `carry_irq` is high exactly while both the carry flag and the carry-interrupt enable are 1.
- R11: Writes to addresses 1 to 8 take effect only while start=0 and are ignored while start=1. Writes to address 0 are always ignored.
- R12: While counting is stopped, every counter holds its value and `sec_tick` stays low.
- R13: Divider reset=1 holds the divider and the sub-second counter at 0 and leaves the time and date fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| carry_irq | output | 1 | Carry interrupt: flag AND enable |

## Verification
The bench loads the time fields and lets one second elapse for each of these dates:
- an ordinary second, a minute boundary, an hour boundary and a midnight (the midnight case also wraps day of week);
- the last day of every month in one common year and one leap year, plus 28 February in the leap year (this tells 28-, 29-, 30- and 31-day months apart);
- 28 February in the years 1900, 2000, 2100 and 2400, which tells the divisible-by-100 and divisible-by-400 exceptions apart from the plain rule;
- 31 December 2099 and 31 December 9999, which cover the century carry and the century wrap.

The bench computes the expected date in binary and converts it to BCD.

Control sequences check three further things:
- that a stopped clock or a missing enable freezes every field;
- that writes made while running are dropped;
- that the flag keeps its value on a write of 1, clears on a write of 0, and gates the interrupt.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int SUB_W     = 7;
  localparam int NUM_UNITS = 8;

  typedef logic [DATA_W-1:0] bcd8_t;

  localparam logic [ADDR_W-1:0] ADR_SUB  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CTL1 = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ADR_CTL2 = ADDR_W'(15);

  // counter chain index; register address is index + 1
  localparam int U_SEC  = 0;
  localparam int U_MIN  = 1;
  localparam int U_HOUR = 2;
  localparam int U_WDAY = 3;
  localparam int U_MDAY = 4;
  localparam int U_MON  = 5;
  localparam int U_YLO  = 6;
  localparam int U_CENT = 7;

  function automatic bcd8_t unit_limit(int u);
    case (u)
      U_SEC, U_MIN: return 8'h59;
      U_HOUR:       return 8'h23;
      U_WDAY:       return 8'h06;
      U_MDAY:       return 8'h31;
      U_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic bcd8_t unit_floor(int u);
    return (u == U_MDAY || u == U_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd8_t unit_reset(int u);
    case (u)
      U_MDAY, U_MON: return 8'h01;
      U_CENT:        return 8'h20;
      default:       return 8'h00;
    endcase
  endfunction

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + u) mod 4 == 0  <=>  u even and t[0] == u[1]
  function automatic logic bcd_div4(bcd8_t v);
    return (v[0] == 1'b0) && (v[4] == v[1]);
  endfunction

  function automatic logic is_leap(bcd8_t cent, bcd8_t ylo);
    return (ylo == 8'h00) ? bcd_div4(cent) : bcd_div4(ylo);
  endfunction

  function automatic bcd8_t month_last(bcd8_t mon, logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_bcd_cnt.sv
module cal_rtc_bcd_cnt
  import cal_rtc_pkg::*;
#(
  parameter logic [7:0] RESET_VAL = 8'h00,
  parameter logic [7:0] FLOOR_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic [7:0] limit,
  output logic [7:0] val,
  output logic       wrap
);

  bcd8_t val_q, val_d;

  // at or beyond the limit the field folds back to its floor
  assign wrap = inc && (val_q >= limit);
  assign val  = val_q;

  always_comb begin
    val_d = val_q;
    if (ld)       val_d = ld_val;
    else if (inc) val_d = wrap ? FLOOR_VAL : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RESET_VAL;
    else        val_q <= val_d;
  end

endmodule

// File: rtl/cal_rtc_prescale.sv
module cal_rtc_prescale
  import cal_rtc_pkg::*;
#(
  parameter int DIV = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [SUB_W-1:0] sub,
  output logic             sec_pulse
);

  localparam int            PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             tick;

  assign tick      = run && (pcnt_q == PMAX);
  assign sec_pulse = tick && (sub_q == '1);
  assign sub       = sub_q;

  always_comb begin
    pcnt_d = pcnt_q;
    sub_d  = sub_q;
    if (clr) begin
      pcnt_d = '0;
      sub_d  = '0;
    end else if (run) begin
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
      if (tick) sub_d = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sub_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      sub_q  <= sub_d;
    end
  end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int PRESCALE_DIV = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sec_tick,
  output logic       carry_irq
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // control state
  logic cf_q, cf_d, cie_q, cie_d;
  logic en_q, en_d, prst_q, prst_d, start_q, start_d;
  logic wr_ctl1, wr_ctl2, run;

  assign wr_ctl1 = reg_wr && (reg_addr == ADR_CTL1);
  assign wr_ctl2 = reg_wr && (reg_addr == ADR_CTL2);
  assign run     = en_q && start_q && !prst_q;

  always_comb begin
    cf_d    = cf_q;
    cie_d   = cie_q;
    en_d    = en_q;
    prst_d  = prst_q;
    start_d = start_q;
    if (wr_ctl1) begin
      cf_d  = cf_q & reg_wdata[7];
      cie_d = reg_wdata[4];
    end
    if (sec_tick) cf_d = 1'b1;
    if (wr_ctl2) begin
      en_d    = reg_wdata[3];
      prst_d  = reg_wdata[1];
      start_d = reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cf_q    <= 1'b0;
      cie_q   <= 1'b0;
      en_q    <= 1'b0;
      prst_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cf_q    <= cf_d;
      cie_q   <= cie_d;
      en_q    <= en_d;
      prst_q  <= prst_d;
      start_q <= start_d;
    end
  end

  assign carry_irq = cf_q & cie_q;

  // sub-second divider
  logic [SUB_W-1:0] sub_val;

  cal_rtc_prescale #(.DIV(PRESCALE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .clr      (prst_q),
    .sub      (sub_val),
    .sec_pulse(sec_tick)
  );

  // BCD counter chain
  bcd8_t unit_val   [NUM_UNITS];
  bcd8_t unit_limit_v [NUM_UNITS];
  logic  unit_inc   [NUM_UNITS];
  logic  unit_wrap  [NUM_UNITS];
  logic  unit_ld    [NUM_UNITS];

  assign unit_inc[U_SEC]  = sec_tick;
  assign unit_inc[U_MIN]  = unit_wrap[U_SEC];
  assign unit_inc[U_HOUR] = unit_wrap[U_MIN];
  assign unit_inc[U_WDAY] = unit_wrap[U_HOUR];
  assign unit_inc[U_MDAY] = unit_wrap[U_HOUR];
  assign unit_inc[U_MON]  = unit_wrap[U_MDAY];
  assign unit_inc[U_YLO]  = unit_wrap[U_MON];
  assign unit_inc[U_CENT] = unit_wrap[U_YLO];

  genvar g;
  generate
    for (g = 0; g < NUM_UNITS; g++) begin : g_unit
      if (g == U_MDAY) begin : g_dyn
        assign unit_limit_v[g] = month_last(unit_val[U_MON],
                                            is_leap(unit_val[U_CENT], unit_val[U_YLO]));
      end else begin : g_fix
        assign unit_limit_v[g] = unit_limit(g);
      end

      assign unit_ld[g] = reg_wr && !start_q && (reg_addr == ADDR_W'(g + 1));

      cal_rtc_bcd_cnt #(
        .RESET_VAL(unit_reset(g)),
        .FLOOR_VAL(unit_floor(g))
      ) u_cnt (
        .clk   (clk),
        .rst_n (rst_core_n),
        .inc   (unit_inc[g]),
        .ld    (unit_ld[g]),
        .ld_val(reg_wdata),
        .limit (unit_limit_v[g]),
        .val   (unit_val[g]),
        .wrap  (unit_wrap[g])
      );
    end
  endgenerate

  // read path
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_SUB) reg_rdata = {1'b0, sub_val};
    if (reg_addr == ADR_CTL1) reg_rdata = {cf_q, 2'b00, cie_q, 4'b0000};
    if (reg_addr == ADR_CTL2) reg_rdata = {4'b0000, en_q, 1'b0, prst_q, start_q};
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (reg_addr == ADDR_W'(i + 1)) reg_rdata = unit_val[i];
    end
  end

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       cf,
  input logic       run,
  input logic       prst,
  input logic       start,
  input logic       reg_wr,
  input logic [7:0] sec,
  input logic [6:0] sub
);

  // R3: the second pulse lasts one cycle
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R4: seconds fold from 59 to 00
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec == 8'h59) |=> (sec == 8'h00));

  // R9: a second advance leaves the flag set
  a_r9_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> cf);

  // R11: while started, seconds move only on a tick
  a_r11_running_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sec_tick) |=> $stable(sec));

  // R12: stopped counters hold
  a_r12_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !prst && !reg_wr) |=> ($stable(sec) && $stable(sub)));

  // R13: divider reset clears the sub-second count
  a_r13_prescale_clear: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> (sub == 7'd0));

endmodule

bind cal_rtc cal_rtc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .sec_tick(sec_tick),
  .cf      (cf_q),
  .run     (run),
  .prst    (prst_q),
  .start   (start_q),
  .reg_wr  (reg_wr),
  .sec     (unit_val[0]),
  .sub     (sub_val)
);

// File: tb/cal_rtc_test.sv
module cal_rtc_test;

  localparam int D = 2;

  logic       clk, rst_n, reg_wr, sec_tick, carry_irq;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int tests, fails;
  int y, mo, dd, wd, hh, mi, ss;

  cal_rtc #(.PRESCALE_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sec_tick(sec_tick), .carry_irq(carry_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int bcd(int v);
    return ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  function automatic bit leap(int yr);
    return ((yr % 4 == 0) && (yr % 100 != 0)) || (yr % 400 == 0);
  endfunction

  function automatic int dim(int yr, int m);
    case (m)
      2:           return leap(yr) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(int a, int d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic advance_expected();
    ss++;
    if (ss == 60) begin ss = 0; mi++; end
    if (mi == 60) begin mi = 0; hh++; end
    if (hh == 24) begin hh = 0; wd = (wd + 1) % 7; dd++; end
    if (dd > dim(y, mo)) begin dd = 1; mo++; end
    if (mo > 12) begin mo = 1; y = (y + 1) % 10000; end
  endtask

  task automatic cmp_time(string req);
    int v;
    reg_read(1, v); check(req, "seconds", v, bcd(ss));
    reg_read(2, v); check(req, "minutes", v, bcd(mi));
    reg_read(3, v); check(req, "hours", v, bcd(hh));
    reg_read(4, v); check(req, "weekday", v, bcd(wd));
    reg_read(5, v); check(req, "day", v, bcd(dd));
    reg_read(6, v); check(req, "month", v, bcd(mo));
    reg_read(7, v); check(req, "year_lo", v, bcd(y % 100));
    reg_read(8, v); check(req, "century", v, bcd(y / 100));
  endtask

  // stop and clear divider, load fields, start, wait one second, compare
  task automatic one_second(string req, int yr, int m, int d, int w, int h, int mn, int s);
    int k, v;
    y = yr; mo = m; dd = d; wd = w; hh = h; mi = mn; ss = s;
    reg_write(15, 8'h02);
    reg_write(1, bcd(ss)); reg_write(2, bcd(mi)); reg_write(3, bcd(hh));
    reg_write(4, bcd(wd)); reg_write(5, bcd(dd)); reg_write(6, bcd(mo));
    reg_write(7, bcd(y % 100)); reg_write(8, bcd(y / 100));
    reg_write(14, 8'h00);
    reg_write(15, 8'h09);
    k = 0;
    do begin @(negedge clk); k++; end while (!sec_tick && k < 2000);
    check("R3", "edges to first tick", k, 128 * D - 1);
    advance_expected();
    cmp_time(req);
    reg_read(14, v); check("R9", "flag after advance", v & 8'h80, 8'h80);
  endtask

  initial begin
    #(150000 * 10);
    tests++; fails++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, v2, n;
    tests = 0; fails = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "sec_tick", int'(sec_tick), 0);
    check("R1", "carry_irq", int'(carry_irq), 0);
    for (int a = 0; a < 16; a++) begin
      int e;
      e = (a == 5 || a == 6) ? 8'h01 : (a == 8) ? 8'h20 : 0;
      reg_read(a, v); check("R1", $sformatf("addr %0d", a), v, e);
    end

    // R2 control bit positions and unused addresses
    reg_write(14, 8'hFF); reg_read(14, v); check("R2", "ctl1 readback", v, 8'h10);
    reg_write(14, 8'h00);
    reg_write(15, 8'h0E); reg_read(15, v); check("R2", "ctl2 readback", v, 8'h0A);
    reg_write(15, 8'h00);
    reg_write(10, 8'h5A); reg_read(10, v); check("R2", "reserved addr", v, 0);
    // R11 sub-second is read-only
    reg_write(0, 8'h55); reg_read(0, v); check("R11", "sub write ignored", v, 0);

    // R4 basic carries
    one_second("R4", 2023, 5, 17, 3, 10, 20, 30);
    one_second("R4", 2023, 5, 17, 3, 10, 20, 59);
    one_second("R4", 2023, 5, 17, 3, 10, 59, 59);
    one_second("R4", 2023, 5, 17, 3, 23, 59, 59);
    // R5 weekday wrap
    one_second("R5", 2023, 5, 20, 6, 23, 59, 59);

    // R6 month lengths, common and leap year
    for (int yi = 0; yi < 2; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int yr;
        yr = 2023 + yi;
        one_second("R6", yr, m, dim(yr, m), 1, 23, 59, 59);
        if (m == 2) one_second("R6", yr, 2, 28, 1, 23, 59, 59);
      end
    end

    // R7 century leap rule
    one_second("R7", 1900, 2, 28, 2, 23, 59, 59);
    one_second("R7", 2000, 2, 28, 2, 23, 59, 59);
    one_second("R7", 2100, 2, 28, 2, 23, 59, 59);
    one_second("R7", 2400, 2, 28, 2, 23, 59, 59);

    // R8 century carry and wrap
    one_second("R8", 2099, 12, 31, 4, 23, 59, 59);
    one_second("R8", 9999, 12, 31, 5, 23, 59, 59);

    // R11 writes while running are dropped (just after a tick)
    one_second("R4", 2023, 7, 1, 0, 8, 0, 0);
    reg_write(1, 8'h42);
    reg_read(1, v); check("R11", "running write ignored", v, bcd(ss));

    // R9 / R10 flag and interrupt (flag set by the last second)
    reg_write(14, 8'h80);
    check("R10", "irq with enable off", int'(carry_irq), 0);
    reg_read(14, v); check("R9", "write 1 keeps flag", v, 8'h80);
    reg_write(14, 8'h90);
    check("R10", "irq with flag and enable", int'(carry_irq), 1);
    reg_write(14, 8'h10);
    check("R10", "irq after flag clear", int'(carry_irq), 0);
    reg_read(14, v); check("R9", "write 0 clears flag", v, 8'h10);
    reg_write(14, 8'h00);

    // R12 stopped: enable only, then start without enable
    reg_write(15, 8'h08);
    reg_read(1, v);
    n = 0;
    repeat (600) begin @(negedge clk); if (sec_tick) n++; end
    check("R12", "ticks while stopped", n, 0);
    reg_read(1, v2); check("R12", "seconds held", v2, v);
    reg_write(15, 8'h01);
    reg_read(0, v);
    n = 0;
    repeat (600) begin @(negedge clk); if (sec_tick) n++; end
    check("R3", "ticks without enable", n, 0);
    reg_read(0, v2); check("R3", "sub held without enable", v2, v);
    cmp_time("R12");

    // R13 divider reset; R3 sub-second rate
    reg_write(15, 8'h02);
    reg_write(15, 8'h09);
    repeat (99) @(negedge clk);
    reg_read(0, v); check("R3", "sub after 100 edges", v, 100 / (2 * D) * 2 / 2 * 0 + 100 / D);
    reg_write(15, 8'h0B);
    reg_read(0, v); check("R13", "sub cleared", v, 0);
    repeat (300) @(negedge clk);
    reg_read(0, v); check("R13", "sub held at 0", v, 0);
    cmp_time("R13");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule